// File: doc/BRIEF.md
# Merging Block Write Buffer

This block sits between a write-through cache and the next memory level. Each write arrives as a byte address, a full block of data and a per-byte enable mask. The buffer keeps up to four pending blocks and hands them downstream one at a time, in the order they arrived, over a valid/ready pair. While it has room, a write is taken in the cycle it is presented, so the writer continues as if the write were already done.

An incoming write is checked against every pending block. If it falls in the same block as a waiting entry, its enabled bytes are folded into that entry and no new slot is used. Folding ORs the byte masks, and the newer bytes replace the older ones. The entry at the head, which is currently offered to memory, never takes a merge, because its contents must stay steady while they are on offer. A write to the head's block therefore takes a fresh slot. The writer is held off only when all four slots are occupied, no waiting non-head entry matches, and the head is not leaving in that same cycle.

Occupancy is tracked by a three-state machine: EMPTY, PARTIAL and FULL. These are the transitions:
- EMPTY to PARTIAL on a new slot.
- PARTIAL to EMPTY when the last entry drains.
- PARTIAL to FULL when the fourth slot fills.
- FULL to PARTIAL when a drain happens with no new slot in the same cycle.

Every other case holds the state. This includes FULL with a write and a drain together, where the write reuses the freed slot.

Top module: `wbuf_merge`

## Requirements
- R1: After reset, mem_valid is 0 and wr_ready is 1.
- R2: When the buffer is not full, wr_ready is 1, so a write is accepted in the cycle it is presented. A write into an empty buffer appears on the memory side in the next cycle. The memory side shows the block address with the low offset bits zero, the written bytes, the mask, and zero in every byte whose mask bit is 0.
- R3: Entries leave in arrival order. One entry retires on each cycle where mem_valid and mem_ready are both 1. While mem_valid is 1 and mem_ready is 0, mem_addr, mem_data and mem_be hold steady.
- R4: A write whose block address (the address bits above the offset) matches a pending non-head entry is merged into that entry. The masks are ORed, newly enabled bytes take the new data, other bytes keep their old data, and no slot is added.
- R5: A write that matches only the head entry is not merged. It takes a new slot at the tail.
- R6: With four entries held, no non-head match and no drain in that cycle, wr_ready is 0 and the buffer contents do not change.
- R7: With four entries held and a drain in the same cycle, wr_ready is 1. A non-merging write is then placed last, in the slot being freed.
- R8: With four entries held, a write matching a non-head entry is accepted by merging, even without a drain.
- R9: The buffer holds exactly four entries. After four distinct writes with no drain, wr_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request from the cache |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | ADDR_W | Byte address of the write; the offset bits are ignored |
| wr_data | input | 8*BLK_BYTES | Block-wide write data |
| wr_be | input | BLK_BYTES | Byte enables for the write |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory takes the head entry |
| mem_addr | output | ADDR_W | Head block address, offset bits zero |
| mem_data | output | 8*BLK_BYTES | Head data; unwritten bytes are zero |
| mem_be | output | BLK_BYTES | Head byte mask |

## Verification
The bench drives a handful of blocks heavily, so merges, head matches and full-buffer cases occur often. A bench-side queue model predicts wr_ready and the head entry on every cycle.

The directed cases target specific failures:
- A full buffer with a matching head: a design that merges into the head corrupts the block while it is on offer to memory.
- A full buffer where a drain and a write meet: a design that ignores the drain stalls the writer for no reason, and a design that writes the wrong slot breaks the drain order.
- A full buffer with a non-head match: a design that stalls here loses the benefit of merging.

Merges with random masks catch a wrong byte priority or a mask that is not ORed.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/wbuf_slot.sv
module wbuf_slot #(
    parameter int TAG_W     = 28,
    parameter int BLK_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   merge_i,
    input  logic                   clear_i,
    input  logic [TAG_W-1:0]       tag_i,
    input  logic [8*BLK_BYTES-1:0] data_i,
    input  logic [BLK_BYTES-1:0]   be_i,
    output logic                   valid_o,
    output logic [TAG_W-1:0]       tag_o,
    output logic [8*BLK_BYTES-1:0] data_o,
    output logic [BLK_BYTES-1:0]   be_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            data_o  <= '0;
            be_o    <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            tag_o   <= tag_i;
            be_o    <= be_i;
            for (int b = 0; b < BLK_BYTES; b++) begin
                data_o[8*b +: 8] <= be_i[b] ? data_i[8*b +: 8] : 8'h00;
            end
        end else if (merge_i) begin
            be_o <= be_o | be_i;
            for (int b = 0; b < BLK_BYTES; b++) begin
                if (be_i[b]) begin
                    data_o[8*b +: 8] <= data_i[8*b +: 8];
                end
            end
        end else if (clear_i) begin
            valid_o <= 1'b0;
        end
    end

    // R4: a merged slot keeps every byte it already had
    a_r4_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_i && !load_i) |=> ((be_o & $past(be_o)) == $past(be_o)));

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int TAG_W = 28,
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic [TAG_W-1:0] tags_i [DEPTH],
    input  logic [PTR_W-1:0] head_i,
    output logic [DEPTH-1:0] hit_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_o[g] = valid_i[g] && (tags_i[g] == tag_i) && (head_i != PTR_W'(g));
    end

    // R4: only one waiting entry can own a block
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid_i,
    input  logic             wr_hit_i,
    input  logic             mem_ready_i,
    output logic             wr_ready_o,
    output logic             mem_valid_o,
    output logic             push_o,
    output logic             pop_o,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o
);

    occ_e             state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [PTR_W-1:0] head_q, head_d;
    logic             full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            head_q  <= head_d;
        end
    end

    always_comb begin
        mem_valid_o = (state_q != OCC_EMPTY);
        full        = (state_q == OCC_FULL);
        pop_o       = mem_valid_o && mem_ready_i;
        wr_ready_o  = !full || wr_hit_i || pop_o;
        push_o      = wr_valid_i && wr_ready_o && !wr_hit_i;
        head_o      = head_q;
        tail_o      = head_q + count_q[PTR_W-1:0];
    end

    always_comb begin
        count_d = count_q + CNT_W'(push_o) - CNT_W'(pop_o);
        head_d  = pop_o ? head_q + PTR_W'(1) : head_q;
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_o) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (count_d == '0)                state_d = OCC_EMPTY;
                else if (count_d == CNT_W'(DEPTH)) state_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (pop_o && !push_o) state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    a_r6_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !wr_ready_o) |=> (count_q == $past(count_q) && head_q == $past(head_q)));

    a_r4_merge_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && !pop_o) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 16,
    parameter int DEPTH     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    output logic                   wr_ready,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [8*BLK_BYTES-1:0] wr_data,
    input  logic [BLK_BYTES-1:0]   wr_be,
    output logic                   mem_valid,
    input  logic                   mem_ready,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [8*BLK_BYTES-1:0] mem_data,
    output logic [BLK_BYTES-1:0]   mem_be
);

    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0]       wr_tag;
    logic [DEPTH-1:0]       slot_valid;
    logic [TAG_W-1:0]       slot_tag  [DEPTH];
    logic [8*BLK_BYTES-1:0] slot_data [DEPTH];
    logic [BLK_BYTES-1:0]   slot_be   [DEPTH];
    logic [DEPTH-1:0]       hit_vec;
    logic                   wr_hit;
    logic                   push, pop;
    logic [PTR_W-1:0]       head, tail;

    assign wr_tag = wr_addr[ADDR_W-1:OFF_W];
    assign wr_hit = wr_valid && (|hit_vec);

    wbuf_match #(.TAG_W(TAG_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_i  (wr_tag),
        .valid_i(slot_valid),
        .tags_i (slot_tag),
        .head_i (head),
        .hit_o  (hit_vec)
    );

    wbuf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_hit_i   (wr_hit),
        .mem_ready_i(mem_ready),
        .wr_ready_o (wr_ready),
        .mem_valid_o(mem_valid),
        .push_o     (push),
        .pop_o      (pop),
        .head_o     (head),
        .tail_o     (tail)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        wbuf_slot #(.TAG_W(TAG_W), .BLK_BYTES(BLK_BYTES)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (push && (tail == PTR_W'(g))),
            .merge_i(wr_hit && hit_vec[g]),
            .clear_i(pop && (head == PTR_W'(g))),
            .tag_i  (wr_tag),
            .data_i (wr_data),
            .be_i   (wr_be),
            .valid_o(slot_valid[g]),
            .tag_o  (slot_tag[g]),
            .data_o (slot_data[g]),
            .be_o   (slot_be[g])
        );
    end

    assign mem_addr = {slot_tag[head], {OFF_W{1'b0}}};
    assign mem_data = slot_data[head];
    assign mem_be   = slot_be[head];

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    a_r2_first_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && wr_valid && wr_ready) |=> mem_valid);

    a_r1_appear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(wr_valid && wr_ready));

endmodule

// File: tb/wbuf_merge_test.sv
module wbuf_merge_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int BLK_BYTES  = 16;
    localparam int DEPTH      = 4;
    localparam int OFF_W      = 4;
    localparam int TAG_W      = ADDR_W - OFF_W;
    localparam int DW         = 8 * BLK_BYTES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [BLK_BYTES-1:0] wr_be = '0;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DW-1:0]     mem_data;
    logic [BLK_BYTES-1:0] mem_be;

    int checks = 0;
    int errors = 0;

    logic [TAG_W-1:0]     qt [DEPTH];
    logic [DW-1:0]        qd [DEPTH];
    logic [BLK_BYTES-1:0] qb [DEPTH];
    int qn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_merge #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be)
    );

    function automatic logic [DW-1:0] byte_mask(input logic [BLK_BYTES-1:0] be);
        logic [DW-1:0] m;
        for (int b = 0; b < BLK_BYTES; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [TAG_W-1:0] tg, input logic [DW-1:0] d,
                        input logic [BLK_BYTES-1:0] be, input bit mr, input string tag_over);
        bit full, pop, hit, exp_rdy;
        int hidx;
        string lbl;
        @(negedge clk);
        wr_valid  = v;
        wr_addr   = {tg, 4'($urandom)};
        wr_data   = d;
        wr_be     = be;
        mem_ready = mr;
        #1;
        full = (qn == DEPTH);
        pop  = (qn > 0) && mr;
        hit  = 1'b0;
        hidx = 0;
        for (int i = 1; i < qn; i++) if (v && qt[i] == tg) begin hit = 1'b1; hidx = i; end
        exp_rdy = !full || hit || pop;
        if (tag_over != "") lbl = tag_over;
        else if (full) lbl = pop ? "R7" : (hit ? "R8" : "R6");
        else lbl = "R2";
        check(wr_ready === exp_rdy, lbl, DW'(wr_ready), DW'(exp_rdy));
        check(mem_valid === (qn > 0), "R3", DW'(mem_valid), DW'(qn > 0));
        if (qn > 0) begin
            check(mem_addr === {qt[0], 4'h0}, "R3", DW'(mem_addr), DW'({qt[0], 4'h0}));
            check(mem_be === qb[0], "R3/R4 mask", DW'(mem_be), DW'(qb[0]));
            check(mem_data === qd[0], "R3/R4 data", mem_data, qd[0]);
        end
        if (v && exp_rdy && hit) begin
            qb[hidx] = qb[hidx] | be;
            qd[hidx] = (qd[hidx] & ~byte_mask(be)) | (d & byte_mask(be));
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                qt[i] = qt[i+1]; qd[i] = qd[i+1]; qb[i] = qb[i+1];
            end
            qn--;
        end
        if (v && exp_rdy && !hit) begin
            qt[qn] = tg; qd[qn] = d & byte_mask(be); qb[qn] = be; qn++;
        end
    endtask

    function automatic logic [DW-1:0] rdata();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(mem_valid === 1'b0, "R1", DW'(mem_valid), '0);
        check(wr_ready === 1'b1, "R1", DW'(wr_ready), DW'(1));

        // R9: fill four distinct blocks with memory stalled
        for (int i = 1; i <= 4; i++) step(1, TAG_W'(i), rdata(), 16'($urandom), 0, "");
        @(negedge clk);
        wr_valid = 0; mem_ready = 0;
        #1;
        check(wr_ready === 1'b0, "R9", DW'(wr_ready), '0);
        // R6: full, new block, no drain
        step(1, TAG_W'(9), rdata(), 16'hFFFF, 0, "");
        // R8 / R4: full, merge into waiting entry of block 3
        step(1, TAG_W'(3), rdata(), 16'h00F0, 0, "");
        step(1, TAG_W'(3), rdata(), 16'h0F0F, 0, "");
        // R5: head block 1 while full, no drain -> stall
        step(1, TAG_W'(1), rdata(), 16'h0001, 0, "");
        // R7: head block 1 while full with drain -> new slot at the end
        step(1, TAG_W'(1), rdata(), 16'h8001, 1, "");
        for (int i = 0; i < 6; i++) step(0, '0, '0, '0, 1, "");

        // R5: head match from a partial buffer takes a second slot
        step(1, TAG_W'(7), rdata(), 16'h00FF, 0, "");
        step(1, TAG_W'(7), rdata(), 16'hFF00, 0, "R5");
        step(0, '0, '0, '0, 1, "");
        @(negedge clk);
        mem_ready = 0;
        #1;
        check(mem_valid === 1'b1 && mem_be === 16'hFF00, "R5", DW'(mem_be), DW'(16'hFF00));
        for (int i = 0; i < 3; i++) step(0, '0, '0, '0, 1, "");

        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 10) < 7, TAG_W'(1 + $urandom % 5), rdata(),
                 16'($urandom), ($urandom % 2) == 0, "");
        end
        for (int i = 0; i < 6; i++) step(0, '0, '0, '0, 1, "");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule